// File: doc/BRIEF.md
# Rational-Ratio Polyphase Resampler

This block changes the sample rate of a signed 16-bit stream by an exact fraction UP/DOWN. It behaves as if the input were zero-stuffed by UP, low-pass filtered by a long prototype FIR designed at UP times the input rate, and then kept only every DOWN-th value. In practice it computes each output directly. It picks one interleaved branch of the prototype table, which holds TAPS*UP entries. It then takes a TAPS-long dot product over consecutive stored inputs through one shared multiply-accumulate unit. For example, a 1.789773 MHz stream gives exactly 44.1 kHz with UP=77/DOWN=3125, and exactly 48 kHz with UP=352/DOWN=13125. The default build uses UP=12, DOWN=487 (about 44101.18 Hz from the same input) and keeps the table small.

Input is a valid/ready stream. A sample is taken on a clock edge where both in_valid and in_ready are high. When in_ready is low, in_valid and in_data are ignored, and the source must hold the sample until it is accepted. The output is a valid-only stream. out_valid is a one-cycle pulse and the sink must take the sample in that cycle, because it is not repeated. The block never stalls output. Back-pressure comes only from the input side, when stored samples run ahead of the current output window.

Top module: `rs_polyphase_resampler`

## Requirements
- R1: Input samples are numbered x[0], x[1], ... in acceptance order. Output n equals the rounded, saturated value of the sum over i=0..TAPS-1 of x[s_n+i]*h[c_n+i*UP]. Here s_n = ceil(n*DOWN/UP), p_n = (n*DOWN) mod UP, and c_n = UP-p_n when p_n is non-zero, else 0.
- R2: The prototype table has TAPS*UP signed Q1.15 entries h[k] = (((37*k+11) mod 211) - 105)*300.
- R3: The full-precision sum is rounded by adding 2^14 and shifting right by 15 bits arithmetically (round half up).
- R4: The rounded value is clamped to the range -32768..32767.
- R5: out_valid is high for exactly one cycle per output and is never high in two consecutive cycles.
- R6: in_ready is low exactly when (samples accepted so far) - s_n >= TAPS+SLACK, where n is the index of the next output. An in_valid presented while in_ready is low adds no sample.
- R7: Output n is not issued before sample x[s_n+TAPS-1] has been accepted.
- R8: When DOWN/UP exceeds TAPS, inputs that fall between two windows are still accepted and contribute to no output.
- R9: After reset, out_valid is low, in_ready is high, and the first output uses p_0=0 and s_0=0.
- R10: When n*DOWN is a multiple of UP, the output uses table offset 0 and a window starting at exactly n*DOWN/UP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Block can take an input sample this cycle |
| out_valid | output | 1 | One-cycle strobe marking an output sample |
| out_data | output | 16 | Signed output sample |

## Verification
Two events can fall on the same edge: an input is accepted, and the finishing output moves the window start forward by DOWN/UP samples. Whether in_ready stays high after that edge then depends on both updates. The bench keeps in_valid busy with random gaps and long unbroken bursts at a ratio where the window jumps past stored samples, so these coincidences happen often. Every cycle it recomputes the expected in_ready from its own count of accepted samples and emitted outputs. It also checks every output against the direct formula.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int FRAC_W   = 15;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;

  // Prototype table entry k, evaluated only with constant arguments.
  function automatic coef_t coef_at(input int k);
    int v;
    v = (((37 * k + 11) % 211) - 105) * 300;
    return coef_t'(v);
  endfunction
endpackage

// File: rtl/rs_phase_track.sv
module rs_phase_track #(
  parameter int UP   = 12,
  parameter int DOWN = 487,
  parameter int CW   = 32,
  parameter int PW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] start_idx,
  output logic [PW-1:0] coef_off,
  output logic [PW-1:0] phase_o
);
  localparam int STEP_P = DOWN % UP;
  localparam int STEP_B = DOWN / UP;

  logic [CW-1:0] base;
  logic [PW-1:0] phase;
  logic [PW:0]   nxt;

  always_comb begin
    nxt = {1'b0, phase} + (PW+1)'(STEP_P);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      phase <= '0;
    end else if (adv) begin
      if (nxt >= (PW+1)'(UP)) begin
        phase <= PW'(nxt - (PW+1)'(UP));
        base  <= base + CW'(STEP_B) + CW'(1);
      end else begin
        phase <= PW'(nxt);
        base  <= base + CW'(STEP_B);
      end
    end
  end

  // A non-zero phase rounds the window start up; offset wraps UP to 0.
  assign start_idx = base + ((phase != '0) ? CW'(1) : CW'(0));
  assign coef_off  = (phase == '0) ? '0 : PW'(UP) - phase;
  assign phase_o   = phase;
endmodule

// File: rtl/rs_sample_buf.sv
module rs_sample_buf #(
  parameter int TAPS  = 4,
  parameter int SLACK = 2,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 32,
  parameter int TW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  rs_pkg::sample_t     in_data,
  output logic                in_ready,
  input  logic [CW-1:0]       start_idx,
  input  logic [TW-1:0]       rd_tap,
  output rs_pkg::sample_t     rd_data,
  output logic                window_ok,
  output logic signed [CW-1:0] fill
);
  localparam logic signed [CW-1:0] HIWAT = CW'(TAPS + SLACK);
  localparam logic signed [CW-1:0] NEED  = CW'(TAPS);

  rs_pkg::sample_t mem [DEPTH];
  logic [CW-1:0]   wr_cnt;
  logic [CW-1:0]   rd_idx;

  assign fill      = $signed(wr_cnt - start_idx);
  assign in_ready  = (fill < HIWAT);
  assign window_ok = (fill >= NEED);
  assign rd_idx    = start_idx + CW'(rd_tap);
  assign rd_data   = mem[rd_idx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_cnt <= '0;
    else if (in_valid && in_ready) wr_cnt <= wr_cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) mem[wr_cnt[AW-1:0]] <= in_data;
  end
endmodule

// File: rtl/rs_mac_engine.sv
module rs_mac_engine #(
  parameter int UP   = 12,
  parameter int TAPS = 4,
  parameter int PW   = 5,
  parameter int TW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [PW-1:0]   coef_off,
  input  rs_pkg::sample_t sample_i,
  output logic [TW-1:0]   tap_o,
  output logic            running,
  output logic            adv,
  output logic            out_valid,
  output rs_pkg::sample_t out_data
);
  localparam int TAB = TAPS * UP;
  localparam int CPW = $clog2(TAB) + 1;
  localparam int ACC = 2 * rs_pkg::SAMPLE_W + $clog2(TAPS) + 1;
  localparam logic signed [ACC-1:0] HALF = ACC'(1 << (rs_pkg::FRAC_W - 1));
  localparam logic signed [ACC-1:0] MAXV = ACC'(32767);
  localparam logic signed [ACC-1:0] MINV = -(ACC'(32768));

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_t;

  rs_pkg::coef_t rom [TAB];
  for (genvar g = 0; g < TAB; g++) begin : g_rom
    assign rom[g] = rs_pkg::coef_at(g);
  end

  st_t                   st;
  logic [TW-1:0]         tap;
  logic [CPW-1:0]        cptr;
  logic signed [ACC-1:0] acc;
  rs_pkg::coef_t         coef;
  logic signed [31:0]    prod;
  logic signed [ACC-1:0] shifted;
  rs_pkg::sample_t       clamped;

  assign coef = (cptr < CPW'(TAB)) ? rom[cptr] : '0;
  assign prod = sample_i * coef;

  always_comb begin
    shifted = (acc + HALF) >>> rs_pkg::FRAC_W;
    if (shifted > MAXV)      clamped = 16'sh7fff;
    else if (shifted < MINV) clamped = 16'sh8000;
    else                     clamped = shifted[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tap       <= '0;
      cptr      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (go) begin
          st   <= ST_RUN;
          tap  <= '0;
          cptr <= CPW'(coef_off);
          acc  <= '0;
        end
        ST_RUN: begin
          acc  <= acc + ACC'(prod);
          tap  <= tap + TW'(1);
          cptr <= cptr + CPW'(UP);
          if (tap == TW'(TAPS - 1)) st <= ST_FIN;
        end
        ST_FIN: begin
          out_valid <= 1'b1;
          out_data  <= clamped;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tap_o   = tap;
  assign running = (st == ST_RUN);
  assign adv     = (st == ST_FIN);
endmodule

// File: rtl/rs_polyphase_resampler.sv
module rs_polyphase_resampler #(
  parameter int UP    = 12,
  parameter int DOWN  = 487,
  parameter int TAPS  = 4,
  parameter int SLACK = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic signed [15:0] in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic signed [15:0] out_data
);
  localparam int CW    = 32;
  localparam int PW    = $clog2(UP) + 1;
  localparam int TW    = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int AW    = (TAPS + SLACK > 1) ? $clog2(TAPS + SLACK) : 1;
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0]        start_idx;
  logic [PW-1:0]        coef_off;
  logic [PW-1:0]        phase;
  logic [TW-1:0]        tap;
  logic                 window_ok;
  logic                 running;
  logic                 adv;
  logic signed [CW-1:0] fill;
  rs_pkg::sample_t      rd_data;

  rs_phase_track #(.UP(UP), .DOWN(DOWN), .CW(CW), .PW(PW)) u_track (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .start_idx(start_idx), .coef_off(coef_off), .phase_o(phase)
  );

  rs_sample_buf #(.TAPS(TAPS), .SLACK(SLACK), .DEPTH(DEPTH), .AW(AW),
                  .CW(CW), .TW(TW)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .start_idx(start_idx), .rd_tap(tap),
    .rd_data(rd_data), .window_ok(window_ok), .fill(fill)
  );

  rs_mac_engine #(.UP(UP), .TAPS(TAPS), .PW(PW), .TW(TW)) u_mac (
    .clk(clk), .rst_n(rst_n), .go(window_ok), .coef_off(coef_off),
    .sample_i(rd_data), .tap_o(tap), .running(running), .adv(adv),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/rs_resampler_chk.sv
module rs_resampler_chk #(
  parameter int UP    = 12,
  parameter int TAPS  = 4,
  parameter int SLACK = 2,
  parameter int CW    = 32,
  parameter int PW    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_valid,
  input logic                 running,
  input logic signed [CW-1:0] fill,
  input logic [CW-1:0]        start_idx,
  input logic [PW-1:0]        phase,
  input logic [PW-1:0]        coef_off
);
  assert_out_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(TAPS + SLACK));

  assert_window_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> fill >= CW'(TAPS));

  assert_window_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> $stable(start_idx));

  assert_branch_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase < PW'(UP)) && (coef_off < PW'(UP)));
endmodule

bind rs_polyphase_resampler rs_resampler_chk #(
  .UP(UP), .TAPS(TAPS), .SLACK(SLACK), .CW(CW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .running(running),
  .fill(fill), .start_idx(start_idx), .phase(phase), .coef_off(coef_off)
);

// File: tb/rs_polyphase_resampler_bench.sv
module rs_polyphase_resampler_bench;
  localparam int UP = 5, DOWN = 23, TAPS = 4, SLACK = 2;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;

  always #10 clk = ~clk;

  rs_polyphase_resampler #(.UP(UP), .DOWN(DOWN), .TAPS(TAPS), .SLACK(SLACK)) u_rs_polyphase_resampler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  int samples[$];
  int n_out = 0, checks = 0, errors = 0, hi_rail = 0, lo_rail = 0;
  bit prev_v = 0, prev_r = 0, prev_ov = 0, done = 0;
  int prev_d = 0;

  function automatic longint coef(longint k);
    return (((37 * k + 11) % 211) - 105) * 300;
  endfunction
  function automatic longint sidx(longint n);
    return (n * DOWN + UP - 1) / UP;
  endfunction
  function automatic longint coff(longint n);
    longint p = (n * DOWN) % UP;
    return (p == 0) ? 0 : UP - p;
  endfunction
  function automatic longint expect_out(longint n);
    longint acc = 0, r;
    for (int i = 0; i < TAPS; i++)
      acc += longint'(samples[sidx(n) + i]) * coef(coff(n) + i * UP);
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One cycle: account for the edge just passed, check, then drive.
  task automatic step(input int mode);
    longint want;
    @(negedge clk);
    if (prev_v && prev_r) samples.push_back(prev_d);
    if (out_valid) begin
      check(!prev_ov, "R5 pulse", 1, 0);
      check(samples.size() >= sidx(n_out) + TAPS, "R7 window arrived",
            samples.size(), sidx(n_out) + TAPS);
      want = expect_out(n_out);
      if ((n_out * DOWN) % UP == 0)
        check(out_data == want, "R10 zero-phase output", out_data, want);
      else
        check(out_data == want, "R1/R2/R3/R4/R8 output", out_data, want);
      if (out_data == 32767) hi_rail++;
      if (out_data == -32768) lo_rail++;
      n_out++;
    end
    prev_ov = out_valid;
    check(in_ready == ((samples.size() - sidx(n_out)) < TAPS + SLACK), "R6 ready",
          in_ready, (samples.size() - sidx(n_out)) < TAPS + SLACK);
    case (mode)
      0: begin in_valid = ($urandom_range(9, 0) < 7); in_data = 16'($signed($urandom_range(16000, 0)) - 8000); end
      1: begin in_valid = 1'b1; in_data = 16'sd32767; end
      2: begin in_valid = 1'b1; in_data = -16'sd32768; end
      3: begin in_valid = 1'b1; in_data = 16'(samples.size() * 977 - 12000); end
      default: begin in_valid = 1'b0; in_data = 16'sd12345; end
    endcase
    prev_v = in_valid; prev_r = in_ready; prev_d = in_data;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
    while (samples.size() < 150) step(0);
    while (samples.size() < 210) step(1);
    while (samples.size() < 270) step(2);
    while (samples.size() < 330) step(3);
    repeat (40) step(4);
    check(n_out >= 60, "R1 output count", n_out, 60);
    check(hi_rail > 0, "R4 positive clamp seen", hi_rail, 1);
    check(lo_rail > 0, "R4 negative clamp seen", lo_rail, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule